// File: doc/BRIEF.md
# Multi-Format Serial PCM Receiver

This block takes a stereo stream of two's-complement audio carried on three wires: a bit clock, a left/right framing clock and a data line. It turns the stream into parallel 24-bit left and right samples. Four framing conventions are handled: left-justified, I2S (MSB one bit clock late), right-justified with a programmable word length, and a DSP-style format in which a short framing pulse marks the start of each channel. A control block drives the format and the right-justified length as static settings. The receiver emits one pair of samples per frame with a one-cycle strobe.

The three serial wires are treated as ordinary inputs sampled by the system clock, which must run several times faster than the bit clock. Bit-clock edges are found by comparing successive samples. Words are received MSB first. A word shorter than 24 bits is left-aligned with zeros below it, and bits past the 24th are dropped.

Top module: `serial_pcm_rx`

## Requirements
- R1: While reset is low and on the first cycle after it, `left_pcm` and `right_pcm` are zero and `pcm_valid` is low.
- R2: `pcm_valid` is a one-cycle pulse. It is raised once per frame, when the right half ends at the next channel boundary. Both sample outputs change only on that cycle and hold otherwise, and a frame without a preceding left half gives no pulse.
- R3: With `fmt_sel`=2'b10 (left-justified), a high framing clock marks the left half. The MSB is the first bit sampled on a rising bit-clock edge after the framing clock changes.
- R4: With `fmt_sel`=2'b01 (I2S), a low framing clock marks the left half. The MSB is the second rising-edge bit after the framing clock changes, and the first bit is ignored.
- R5: With `fmt_sel`=2'b00 (right-justified), a high framing clock marks the left half. Capture starts at the zero-based rising-edge position 8, 12 or 16 counted from the change, for `rj_len_sel` 2'b00 (24 bits), 2'b01 (20 bits) or 2'b10 (16 bits); 2'b11 acts as 24 bits. The start position does not depend on frame length, so a longer word sent in a short setting yields only its low bits.
- R6: With `fmt_sel`=2'b11 (DSP), data and framing are sampled on falling bit-clock edges. A framing clock sampled high after being low starts a channel, and the MSB is the next sample with the framing clock low. The first pulse after reset is the left channel, and channels then alternate.
- R7: A word of fewer than 24 bits appears left-aligned in the 24-bit output with zeros in the low bits.
- R8: In every format except right-justified, bits after the 24th in a half frame are dropped without error. The output holds the first 24 bits received.
- R9: Left-justified frames as short as twice the word length (24 bit clocks per half for 24-bit words) are received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| bck_in | input | 1 | Serial bit clock |
| lrc_in | input | 1 | Left/right framing clock |
| sd_in | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Framing format: 00 right-justified, 01 I2S, 10 left-justified, 11 DSP |
| rj_len_sel | input | 2 | Right-justified word length: 00 24, 01 20, 10 16, 11 24 |
| left_pcm | output | 24 | Last complete left sample |
| right_pcm | output | 24 | Last complete right sample |
| pcm_valid | output | 1 | One-cycle strobe when a new sample pair is presented |

## Verification
A wrong bit position counter or start offset shows up as a left or right sample that is shifted or has its low bits cut. This appears at the end of the very frame in which the fault occurs, because each half is captured afresh from its own boundary. A wrong channel flag shows first as a missing or doubled strobe, or as swapped outputs, one frame after the bad boundary. Sweeping word lengths below, at and above 24 in every format, with all-ones, single-MSB and mixed patterns, makes each alignment error change a value the bench computes from the shift rules.

// File: rtl/srx_pkg.sv
// Shared types and helpers for the serial PCM receiver.
package srx_pkg;

    // Framing formats selected by the control block.
    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_I2S = 2'b01,
        FMT_LJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    // Word length used by the right-justified format.
    function automatic int rj_word_len(input logic [1:0] sel);
        case (sel)
            2'b01:   return 20;
            2'b10:   return 16;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/srx_edge_sync.sv
// Finds the capture edge of the bit clock from system-clock samples.
// Assumes the serial lines are already synchronous to clk and that each
// bit-clock phase lasts at least one clk period. DSP format captures on
// the falling edge; all others capture on the rising edge.
module srx_edge_sync
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bck,
    input  logic       lrc,
    input  logic       dat,
    input  logic [1:0] fmt,
    output logic       cap,
    output logic       lr_bit,
    output logic       d_bit
);

    logic [2:0] smp;
    logic       bck_d;
    logic       rise;
    logic       fall;

    // Register the three serial lines and the previous bit-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp   <= '0;
            bck_d <= 1'b0;
        end else begin
            smp   <= {bck, lrc, dat};
            bck_d <= smp[2];
        end
    end

    // Pick the active edge for the current format.
    always_comb begin
        rise   = smp[2] & ~bck_d;
        fall   = ~smp[2] & bck_d;
        cap    = (fmt == FMT_DSP) ? fall : rise;
        lr_bit = smp[1];
        d_bit  = smp[0];
    end

endmodule

// File: rtl/srx_frame_track.sv
// Tracks channel boundaries and the bit position inside each half frame.
// On every capture edge it reports whether the edge opens a new half,
// whether a finished half exists and its channel, and whether the bit
// sampled on this edge belongs to the word.
module srx_frame_track
    import srx_pkg::*;
#(
    parameter int POS_W     = 6,
    parameter int SLOT_BITS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap,
    input  logic       lr_bit,
    input  logic [1:0] fmt,
    input  logic [1:0] rj_len,
    output logic       bnd,
    output logic       fin_valid,
    output logic       fin_right,
    output logic       accept
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic             lr_prev;
    logic             primed;
    logic             ch_right;
    logic             active;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] pos_now;
    logic [POS_W-1:0] start;
    logic             dsp;
    logic             new_right;

    // Boundary detection, bit position and word-membership decision.
    always_comb begin
        dsp       = (fmt == FMT_DSP);
        bnd       = dsp ? (lr_bit & ~lr_prev) : (~primed | (lr_bit ^ lr_prev));
        pos_now   = bnd ? '0 : pos;
        new_right = dsp ? (active & ~ch_right)
                        : ((fmt == FMT_I2S) ? lr_bit : ~lr_bit);
        case (fmt)
            FMT_RJ:  start = POS_W'(SLOT_BITS - rj_word_len(rj_len));
            FMT_I2S: start = POS_W'(1);
            default: start = '0;
        endcase
        accept    = dsp ? (~lr_bit & active) : (pos_now >= start);
        fin_valid = bnd & active;
        fin_right = ch_right;
    end

    // Advance position and channel state on each capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_prev  <= 1'b0;
            primed   <= 1'b0;
            ch_right <= 1'b0;
            active   <= 1'b0;
            pos      <= '0;
        end else if (cap) begin
            lr_prev <= lr_bit;
            primed  <= 1'b1;
            pos     <= (pos_now == POS_MAX) ? pos_now : pos_now + POS_W'(1);
            if (bnd) begin
                ch_right <= new_right;
                active   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/srx_word_asm.sv
// Shifts accepted bits into a word, stops after W bits, and presents the
// finished word left-aligned with zero fill. A boundary restarts the word;
// the bit on the boundary edge may itself be the first bit of the word.
module srx_word_asm #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         bnd,
    input  logic         accept,
    input  logic         d_bit,
    output logic [W-1:0] word_out
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     sr;
    logic [CNT_W-1:0] cnt;

    // Left-align the collected bits.
    always_comb begin
        word_out = sr << (CNT_W'(W) - cnt);
    end

    // Collect bits, restarting at each boundary and saturating at W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (cap) begin
            if (bnd) begin
                sr  <= accept ? {{(W-1){1'b0}}, d_bit} : '0;
                cnt <= accept ? CNT_W'(1) : '0;
            end else if (accept && (cnt < CNT_W'(W))) begin
                sr  <= {sr[W-2:0], d_bit};
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/serial_pcm_rx.sv
// Multi-format serial PCM receiver top. Holds the finished left word until
// the right half closes, then presents both with a one-cycle strobe.
// Assumes fmt_sel and rj_len_sel stay static while frames arrive.
module serial_pcm_rx
    import srx_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_BITS = 32,
    parameter int POS_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bck_in,
    input  logic                lrc_in,
    input  logic                sd_in,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          rj_len_sel,
    output logic [SAMPLE_W-1:0] left_pcm,
    output logic [SAMPLE_W-1:0] right_pcm,
    output logic                pcm_valid
);

    logic                cap_edge;
    logic                lr_bit;
    logic                d_bit;
    logic                bnd;
    logic                fin_valid;
    logic                fin_right;
    logic                accept;
    logic [SAMPLE_W-1:0] word;
    logic [SAMPLE_W-1:0] left_hold;
    logic                left_rdy;

    srx_edge_sync u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .bck    (bck_in),
        .lrc    (lrc_in),
        .dat    (sd_in),
        .fmt    (fmt_sel),
        .cap    (cap_edge),
        .lr_bit (lr_bit),
        .d_bit  (d_bit)
    );

    srx_frame_track #(
        .POS_W     (POS_W),
        .SLOT_BITS (SLOT_BITS)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap_edge),
        .lr_bit    (lr_bit),
        .fmt       (fmt_sel),
        .rj_len    (rj_len_sel),
        .bnd       (bnd),
        .fin_valid (fin_valid),
        .fin_right (fin_right),
        .accept    (accept)
    );

    srx_word_asm #(
        .W (SAMPLE_W)
    ) u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap_edge),
        .bnd      (bnd),
        .accept   (accept),
        .d_bit    (d_bit),
        .word_out (word)
    );

    // Pair finished halves and publish them when the right half closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold <= '0;
            left_rdy  <= 1'b0;
            left_pcm  <= '0;
            right_pcm <= '0;
            pcm_valid <= 1'b0;
        end else begin
            pcm_valid <= 1'b0;
            if (cap_edge && fin_valid) begin
                if (fin_right) begin
                    if (left_rdy) begin
                        left_pcm  <= left_hold;
                        right_pcm <= word;
                        pcm_valid <= 1'b1;
                        left_rdy  <= 1'b0;
                    end
                end else begin
                    left_hold <= word;
                    left_rdy  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/srx_checker.sv
// Temporal checks on the serial PCM receiver, bound to its top module.
module srx_checker #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bck_in,
    input logic [1:0]          fmt_sel,
    input logic                cap_edge,
    input logic [SAMPLE_W-1:0] left_pcm,
    input logic [SAMPLE_W-1:0] right_pcm,
    input logic                pcm_valid
);

    // Outputs are clear on the first cycle out of reset.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (left_pcm == '0 && right_pcm == '0 && !pcm_valid));

    // The strobe never lasts two cycles.
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |=> !pcm_valid);

    // Samples hold whenever no strobe is raised.
    p_hold_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_valid |-> ($stable(left_pcm) && $stable(right_pcm)));

    // A strobe follows a capture edge.
    p_valid_after_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> $past(cap_edge));

    // The edge that closed the frame has the format's sense: falling for DSP.
    p_edge_sense_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> (($past(fmt_sel) == 2'b11)
                       ? (!$past(bck_in, 2) && $past(bck_in, 3))
                       : ($past(bck_in, 2) && !$past(bck_in, 3))));

endmodule

bind serial_pcm_rx srx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bck_in    (bck_in),
    .fmt_sel   (fmt_sel),
    .cap_edge  (cap_edge),
    .left_pcm  (left_pcm),
    .right_pcm (right_pcm),
    .pcm_valid (pcm_valid)
);

// File: tb/serial_pcm_rx_test.sv
// Sweeps word lengths and patterns through all four framing formats.
module serial_pcm_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck = 1'b0;
    logic        lrc = 1'b0;
    logic        sd = 1'b0;
    logic [1:0]  fmt = 2'b10;
    logic [1:0]  rjl = 2'b00;
    logic [23:0] left_pcm;
    logic [23:0] right_pcm;
    logic        pcm_valid;

    int total = 0;
    int fails = 0;
    logic prev_v = 1'b0;
    logic [23:0] ql[$];
    logic [23:0] qr[$];
    string       qt[$];

    always #4 clk = ~clk;

    serial_pcm_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bck_in     (bck),
        .lrc_in     (lrc),
        .sd_in      (sd),
        .fmt_sel    (fmt),
        .rj_len_sel (rjl),
        .left_pcm   (left_pcm),
        .right_pcm  (right_pcm),
        .pcm_valid  (pcm_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input int nb);
        return (nb >= 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
    endfunction

    // R7/R8: left-align short words, keep the first 24 bits of long ones.
    function automatic logic [23:0] exp_fill(input logic [31:0] w, input int nb);
        if (nb >= 24) return 24'(w >> (nb - 24));
        return 24'(w << (24 - nb));
    endfunction

    // R5: capture holds the low 'len' bits of the right-justified slot.
    function automatic logic [23:0] exp_rj(input logic [31:0] w, input int len);
        return 24'((w & mask_of(len)) << (24 - len));
    endfunction

    function automatic logic [31:0] pat(input int k, input int nb);
        logic [31:0] v;
        case (k)
            0:       v = 32'hFFFF_FFFF;
            1:       v = 32'd1 << (nb - 1);
            default: v = 32'h9E37_79B9 ^ (32'(nb) * 32'h0101_0101);
        endcase
        return v & mask_of(nb);
    endfunction

    // One bit period; DSP data changes with the rising edge, others with the falling.
    task automatic bit_out(input logic lr, input logic d);
        if (fmt == 2'b11) begin
            bck = 1'b1; lrc = lr; sd = d;
            repeat (2) @(negedge clk);
            bck = 1'b0;
            repeat (2) @(negedge clk);
        end else begin
            bck = 1'b0; lrc = lr; sd = d;
            repeat (2) @(negedge clk);
            bck = 1'b1;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [31:0] lw, input logic [31:0] rw, input int nb, input int hl);
        for (int ch = 0; ch < 2; ch++) begin
            logic [31:0] w;
            w = (ch == 0) ? lw : rw;
            for (int p = 0; p < hl; p++) begin
                logic lr;
                logic d;
                case (fmt)
                    2'b10: begin lr = (ch == 0); d = (p < nb) ? w[nb-1-p] : 1'b0; end
                    2'b01: begin lr = (ch == 1); d = (p >= 1 && p <= nb) ? w[nb-p] : 1'b0; end
                    2'b00: begin lr = (ch == 0); d = (p >= 32 - nb) ? w[31-p] : 1'b0; end
                    default: begin
                        lr = (p == 0);
                        d  = (p >= 1 && p <= nb) ? w[nb-p] : 1'b0;
                    end
                endcase
                bit_out(lr, d);
            end
        end
    endtask

    task automatic expect_frame(input logic [31:0] lw, input logic [31:0] rw, input int nb,
                                input int hl, input logic [23:0] el, input logic [23:0] er,
                                input string tag);
        ql.push_back(el); qr.push_back(er); qt.push_back(tag);
        send_frame(lw, rw, nb, hl);
    endtask

    task automatic start_group(input logic [1:0] f, input logic [1:0] r);
        @(negedge clk);
        rst_n = 1'b0; bck = 1'b0; lrc = 1'b0; sd = 1'b0; fmt = f; rjl = r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // A trailing frame closes the last real right half; then nothing may be pending.
    task automatic end_group();
        send_frame(32'h0, 32'h0, 24, 32);
        repeat (8) @(negedge clk);
        chk(ql.size() == 0, "R2 pending frames without strobe", 32'(ql.size()), 32'd0);
        ql.delete(); qr.delete(); qt.delete();
    endtask

    task automatic sweep(input string mode_tag, input int extra);
        int nbs[5] = '{16, 18, 20, 24, 32};
        foreach (nbs[i]) begin
            for (int k = 0; k < 3; k++) begin
                int nb;
                logic [31:0] lw;
                logic [31:0] rw;
                string tag;
                nb = nbs[i];
                lw = pat(k, nb);
                rw = ~lw & mask_of(nb);
                tag = (nb > 24) ? "R8 long word" : (nb < 24) ? "R7 short word" : mode_tag;
                expect_frame(lw, rw, nb, (nb + extra > 32) ? nb + extra : 32,
                             exp_fill(lw, nb), exp_fill(rw, nb), tag);
            end
        end
    endtask

    // Strobe monitor: compare each published pair with the expected queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pcm_valid) begin
                chk(!prev_v, "R2 strobe longer than one cycle", 32'(prev_v), 32'd0);
                if (ql.size() == 0) begin
                    chk(1'b0, "R2 unexpected strobe", 32'(left_pcm), 32'd0);
                end else begin
                    logic [23:0] el;
                    logic [23:0] er;
                    string t;
                    el = ql.pop_front(); er = qr.pop_front(); t = qt.pop_front();
                    chk(left_pcm == el, {t, " left"}, 32'(left_pcm), 32'(el));
                    chk(right_pcm == er, {t, " right"}, 32'(right_pcm), 32'(er));
                end
            end
            prev_v = pcm_valid;
        end else begin
            prev_v = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(left_pcm == 24'd0 && right_pcm == 24'd0, "R1 outputs in reset", 32'(left_pcm), 32'd0);
        chk(!pcm_valid, "R1 strobe in reset", 32'(pcm_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(left_pcm == 24'd0 && !pcm_valid, "R1 outputs after reset", 32'(left_pcm), 32'd0);

        // R3 left-justified sweep, then R9 minimum frame length
        start_group(2'b10, 2'b00);
        sweep("R3 left-justified", 0);
        expect_frame(32'h00C3_A51F, 32'h003C_5AE0, 24, 24, 24'hC3A51F, 24'h3C5AE0, "R9 short frame");
        expect_frame(32'h0080_0001, 32'h007F_FFFE, 24, 24, 24'h800001, 24'h7FFFFE, "R9 short frame");
        end_group();

        // R4 I2S sweep (one-bit delay needs nb+1 slots)
        start_group(2'b01, 2'b00);
        sweep("R4 I2S", 1);
        end_group();

        // R6 DSP sweep (pulse plus nb bits)
        start_group(2'b11, 2'b00);
        sweep("R6 DSP pulse", 2);
        end_group();

        // R5 right-justified at each length, plus an oversize word in 16-bit setting
        for (int s = 0; s < 3; s++) begin
            int len;
            len = (s == 0) ? 24 : (s == 1) ? 20 : 16;
            start_group(2'(s), 2'(s));
            fmt = 2'b00;
            for (int k = 0; k < 3; k++) begin
                logic [31:0] lw;
                logic [31:0] rw;
                lw = pat(k, len);
                rw = ~lw & mask_of(len);
                expect_frame(lw, rw, len, 32, exp_rj(lw, len), exp_rj(rw, len), "R5 right-justified");
            end
            if (len == 16) begin
                expect_frame(32'h00AB_CDEF, 32'h0012_3456, 24, 32,
                             exp_rj(32'h00AB_CDEF, 16), exp_rj(32'h0012_3456, 16),
                             "R5 fixed offset drops high bits");
            end
            end_group();
        end

        // R5: setting 2'b11 behaves as 24 bits
        start_group(2'b00, 2'b11);
        expect_frame(32'h00F0_0F5A, 32'h000F_F0A5, 24, 32, 24'hF00F5A, 24'h0FF0A5, "R5 length code 11");
        end_group();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule